// File: doc/BRIEF.md
# Linear Systolic SAD Array

This block evaluates block-matching candidates for full-search motion estimation. A chain of sixteen processing elements compares a 16x16 current block against a 31x31 reference window, covering horizontal and vertical offsets from -8 to +7. Each element owns one horizontal offset. The vertical offset advances once per 64-cycle pass, and sixteen passes cover the whole window. Every element reports one 4x4 sum of absolute differences per sub-block and tags it with its motion vector and its sub-block index.

Pixels enter at the head of the chain as 4-pixel vertical columns, and the block has no request handshake. Every column arrives at a fixed cycle that is counted from the accepted start pulse. Current columns advance one register per element. Reference columns travel down two-register-per-element chains, so neighbouring elements see data one cycle apart and pair each current column with a reference column offset by one more place. Two reference ports take turns: one feeds even 4-row strips and the other feeds odd strips. Each strip's reference stream is therefore 31 columns long while the current data moves on every 16 cycles. After a fill of 15 cycles, every element does useful work on every cycle. The whole search takes 1024 cycles in steady state.

Top module: `sad_systolic_array`

## Requirements
- R1: After reset, `busy`, `done` and every bit of `sadValid` are low, and `sadValid` stays all-zero whenever `busy` is low.
- R2: A `start` pulse seen while idle raises `busy` on the next cycle. A `start` seen while `busy` is ignored and does not change the timing of any output.
- R3: With the start-accepting edge counted as edge 0, the column on `curCol` at edge n+1 is stream element n. For 15 <= n <= 1038, with j = n-15, that element is column x = j%16 of the current block, rows 4s..4s+3 where s = (j/16)%4. Row r sits at bits [8r+7:8r].
- R4: For pass p = j/64 (vertical offset dy = p-8) and strip s, the reference element at stream index n = 64p+16s+15+u (-15 <= u <= 15) is reference column 7+u, rows 4s+dy..4s+dy+3. It arrives on `refColA` for even s and on `refColB` for odd s, with the same row packing as R3.
- R5: Element k reports `mvDx` = 7-k and `mvDy` = p-8, each as a 5-bit two's-complement field at bits [5k+4:5k].
- R6: Each result on `sadVal` (12 bits at [12k+11:12k]) equals the sum of the 16 absolute differences between a 4x4 current sub-block and the reference displaced by (mvDx, mvDy). `blkIdx` (4 bits at [4k+3:4k]) is 4*row-of-sub-block + column-of-sub-block.
- R7: The sub-block whose last column is stream element j appears from element k with `sadValid[k]` high for exactly one cycle, after edge j+k+2. Within a pass, results come every 4 cycles.
- R8: Element k+1 emits each result exactly one cycle after element k.
- R9: `done` pulses for one cycle after edge 1056, which is one cycle after the final result of element 15. `busy` falls on the same edge.
- R10: Each element emits exactly 256 results per search (16 vertical offsets times 16 sub-blocks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (honoured only while idle) |
| curCol | input | 32 | Current-frame column of 4 pixels |
| refColA | input | 32 | Reference column for even strips |
| refColB | input | 32 | Reference column for odd strips |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| sadValid | output | 16 | Per-element result strobe |
| sadVal | output | 192 | Per-element 4x4 SAD values |
| mvDx | output | 80 | Per-element horizontal offset |
| mvDy | output | 80 | Per-element vertical offset |
| blkIdx | output | 64 | Per-element sub-block index |

## Verification
The result of the sub-block that closes with stream element j is due from element k exactly j+k+2 edges after the start edge. `done` is due at edge 1056. The bench numbers every edge from the start edge and samples at the falling edge that follows. For each element it computes which stream element should be retiring there, so a result that arrives one cycle early or late shows up as a strobe mismatch. The values come from plain loops over the stored pixel arrays. A start pulse injected mid-search must leave the same schedule intact.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int NPE = 16;                    // elements, also the offset count per axis
  localparam int MB = 16;                     // macroblock edge
  localparam int SUB = 4;                     // sub-block edge
  localparam int PIX_W = 8;
  localparam int STRIPS = MB / SUB;
  localparam int PASS_LEN = MB * STRIPS;      // cycles per vertical offset
  localparam int FILL = NPE - 1;              // reference lead before the first current column
  localparam int CUR_LAST = FILL + NPE * PASS_LEN - 1;
  localparam int DONE_AT = CUR_LAST + NPE + 1;
  localparam int REF_TAPS = 2 * (NPE - 1) + 1;
  localparam int SAD_W = PIX_W + $clog2(SUB * SUB);
  localparam int MV_W = $clog2(NPE) + 1;
  localparam int IDX_W = $clog2(NPE);
  localparam int COL_W = $clog2(MB);
  localparam int STRIP_W = $clog2(STRIPS);
  localparam int SUBC_W = $clog2(SUB);
  localparam int BLK_W = STRIP_W + COL_W - SUBC_W;
  localparam int CNT_W = $clog2(DONE_AT + 1);
  localparam int VEC_W = SUB * PIX_W;

  typedef struct packed {
    logic              curValid;
    logic              stripOdd;
    logic              lastCol;
    logic [IDX_W-1:0]  dyIdx;
    logic [BLK_W-1:0]  blkIdx;
  } sadStrobe_t;
endpackage

// File: rtl/sad_ctrl.sv
module sad_ctrl
  import sad_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output sadStrobe_t strobe
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] rel;
  logic [COL_W-1:0] col;
  logic [STRIP_W-1:0] strip;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        cnt <= '0;
        if (start) busy <= 1'b1;
      end else if (cnt == CNT_W'(DONE_AT)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // Decode the stream position into the tag that rides with the current column
  always_comb begin
    rel   = cnt - CNT_W'(FILL);
    col   = rel[COL_W-1:0];
    strip = rel[COL_W +: STRIP_W];
    strobe.curValid = busy && (cnt >= CNT_W'(FILL)) && (cnt <= CNT_W'(CUR_LAST));
    strobe.stripOdd = strip[0];
    strobe.lastCol  = &col[SUBC_W-1:0];
    strobe.dyIdx    = rel[COL_W+STRIP_W +: IDX_W];
    strobe.blkIdx   = {strip, col[COL_W-1:SUBC_W]};
  end
endmodule

// File: rtl/sad_pe.sv
module sad_pe
  import sad_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [VEC_W-1:0]  curVec,
  input  logic [VEC_W-1:0]  refA,
  input  logic [VEC_W-1:0]  refB,
  input  sadStrobe_t        tag,
  output logic              outValid,
  output logic [SAD_W-1:0]  outSad,
  output logic [MV_W-1:0]   outDy,
  output logic [BLK_W-1:0]  outBlk
);
  logic [VEC_W-1:0] refSel;
  logic [SAD_W-1:0] colSum;
  logic [SAD_W-1:0] acc;

  always_comb begin
    logic [PIX_W-1:0] a, b;
    refSel = tag.stripOdd ? refB : refA;
    colSum = '0;
    for (int r = 0; r < SUB; r++) begin
      a = curVec[r*PIX_W +: PIX_W];
      b = refSel[r*PIX_W +: PIX_W];
      colSum = colSum + SAD_W'((a > b) ? (a - b) : (b - a));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSad   <= '0;
      outDy    <= '0;
      outBlk   <= '0;
      acc      <= '0;
    end else begin
      outValid <= 1'b0;
      if (tag.curValid) begin
        if (tag.lastCol) begin
          outValid <= 1'b1;
          outSad   <= acc + colSum;
          outDy    <= MV_W'(tag.dyIdx) - MV_W'(NPE / 2);
          outBlk   <= tag.blkIdx;
          acc      <= '0;
        end else begin
          acc <= acc + colSum;
        end
      end
    end
  end
endmodule

// File: rtl/sad_datapath.sv
module sad_datapath
  import sad_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  sadStrobe_t            strobe,
  input  logic [VEC_W-1:0]      curCol,
  input  logic [VEC_W-1:0]      refColA,
  input  logic [VEC_W-1:0]      refColB,
  output logic [NPE-1:0]        sadValid,
  output logic [NPE*SAD_W-1:0]  sadVal,
  output logic [NPE*MV_W-1:0]   mvDx,
  output logic [NPE*MV_W-1:0]   mvDy,
  output logic [NPE*BLK_W-1:0]  blkIdx
);
  logic [VEC_W-1:0] curPipe  [NPE];
  sadStrobe_t       tagPipe  [NPE];
  logic [VEC_W-1:0] refPipeA [REF_TAPS];
  logic [VEC_W-1:0] refPipeB [REF_TAPS];

  // Current data and its tag skew by one register per element, reference by two
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NPE; i++) begin
        curPipe[i] <= '0;
        tagPipe[i] <= '0;
      end
      for (int i = 0; i < REF_TAPS; i++) begin
        refPipeA[i] <= '0;
        refPipeB[i] <= '0;
      end
    end else begin
      curPipe[0]  <= curCol;
      tagPipe[0]  <= strobe;
      refPipeA[0] <= refColA;
      refPipeB[0] <= refColB;
      for (int i = 1; i < NPE; i++) begin
        curPipe[i] <= curPipe[i-1];
        tagPipe[i] <= tagPipe[i-1];
      end
      for (int i = 1; i < REF_TAPS; i++) begin
        refPipeA[i] <= refPipeA[i-1];
        refPipeB[i] <= refPipeB[i-1];
      end
    end
  end

  for (genvar k = 0; k < NPE; k++) begin : g_pe
    localparam int DX = NPE / 2 - 1 - k;
    sad_pe u_pe (
      .clk      (clk),
      .rstN     (rstN),
      .curVec   (curPipe[k]),
      .refA     (refPipeA[2*k]),
      .refB     (refPipeB[2*k]),
      .tag      (tagPipe[k]),
      .outValid (sadValid[k]),
      .outSad   (sadVal[k*SAD_W +: SAD_W]),
      .outDy    (mvDy[k*MV_W +: MV_W]),
      .outBlk   (blkIdx[k*BLK_W +: BLK_W])
    );
    assign mvDx[k*MV_W +: MV_W] = MV_W'(DX);
  end
endmodule

// File: rtl/sad_systolic_array.sv
module sad_systolic_array
  import sad_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [VEC_W-1:0]      curCol,
  input  logic [VEC_W-1:0]      refColA,
  input  logic [VEC_W-1:0]      refColB,
  output logic                  busy,
  output logic                  done,
  output logic [NPE-1:0]        sadValid,
  output logic [NPE*SAD_W-1:0]  sadVal,
  output logic [NPE*MV_W-1:0]   mvDx,
  output logic [NPE*MV_W-1:0]   mvDy,
  output logic [NPE*BLK_W-1:0]  blkIdx
);
  sadStrobe_t strobe;

  sad_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .strobe (strobe)
  );

  sad_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .curCol   (curCol),
    .refColA  (refColA),
    .refColB  (refColB),
    .sadValid (sadValid),
    .sadVal   (sadVal),
    .mvDx     (mvDx),
    .mvDy     (mvDy),
    .blkIdx   (blkIdx)
  );
endmodule

// File: rtl/sad_checker.sv
module sad_checker
  import sad_pkg::*;
(
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [NPE-1:0] sadValid
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sadValid == '0));

  p_start_launch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy && !done) |=> (busy || done));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(sadValid[NPE-1])));

  for (genvar k = 0; k < NPE; k++) begin : g_chk
    p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
      sadValid[k] |=> !sadValid[k]);
    if (k < NPE - 1) begin : g_next
      p_neighbour_skew_r8: assert property (@(posedge clk) disable iff (!rstN)
        sadValid[k] |=> sadValid[k+1]);
    end
  end
endmodule

bind sad_systolic_array sad_checker u_sad_checker (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .sadValid (sadValid)
);

// File: tb/test_sad_systolic_array.sv
`timescale 1ns/1ps
module test_sad_systolic_array;
  localparam int N = 16;
  localparam int SW = 12;
  localparam int MW = 5;
  localparam int BW = 4;
  localparam int LAST_CUR = 1038;
  localparam int DONE_EDGE = 1056;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] curCol = '0, refColA = '0, refColB = '0;
  logic busy, done;
  logic [N-1:0] sadValid;
  logic [N*SW-1:0] sadVal;
  logic [N*MW-1:0] mvDx, mvDy;
  logic [N*BW-1:0] blkIdx;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int curPx [16][16];
  int refPx [31][31];   // index = coordinate + 8
  int emitted [N];

  always #2.5 clk = ~clk;

  sad_systolic_array i_sad_systolic_array (
    .clk(clk), .rstN(rstN), .start(start), .curCol(curCol),
    .refColA(refColA), .refColB(refColB), .busy(busy), .done(done),
    .sadValid(sadValid), .sadVal(sadVal), .mvDx(mvDx), .mvDy(mvDy), .blkIdx(blkIdx)
  );

  task automatic fillPixels();
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) curPx[r][c] = $urandom_range(0, 255);
    for (int r = 0; r < 31; r++)
      for (int c = 0; c < 31; c++) refPx[r][c] = $urandom_range(0, 255);
  endtask

  function automatic logic [31:0] curFor(int n);
    logic [31:0] v = '0;
    if (n >= 15 && n <= LAST_CUR) begin
      int j = n - 15;
      int s = (j / 16) % 4;
      int x = j % 16;
      for (int r = 0; r < 4; r++) v[r*8 +: 8] = 8'(curPx[4*s+r][x]);
    end
    return v;
  endfunction

  function automatic logic [31:0] refFor(int n, int parity);
    logic [31:0] v = '0;
    for (int p = 0; p < 16; p++) begin
      for (int s = parity; s < 4; s += 2) begin
        int u = n - (64*p + 16*s + 15);
        if (u >= -15 && u <= 15) begin
          for (int r = 0; r < 4; r++)
            v[r*8 +: 8] = 8'(refPx[4*s + r + (p-8) + 8][7 + u + 8]);
        end
      end
    end
    return v;
  endfunction

  function automatic int expSad(int j, int dx, int dy);
    int s = ((j - 15) / 16) % 4;
    int x = (j - 15) % 16;
    int acc = 0;
    for (int r = 4*s; r < 4*s + 4; r++)
      for (int c = x - 3; c <= x; c++) begin
        int d = curPx[r][c] - refPx[r+dy+8][c+dx+8];
        acc += (d < 0) ? -d : d;
      end
    return acc;
  endfunction

  task automatic fail(string req, string what, int k, int act, int exp_v);
    failures++;
    $display("FAIL %s %s pe=%0d actual=%0d expected=%0d", req, what, k, act, exp_v);
  endtask

  // e = edges since the start-accepting edge
  task automatic checkCycle(int e);
    bit expBusy = (e <= DONE_EDGE - 1);
    bit expDone = (e == DONE_EDGE);
    checks++;
    if (busy !== expBusy) fail("R2", "busy", -1, busy, expBusy);
    checks++;
    if (done !== expDone) fail("R9", "done", -1, done, expDone);
    for (int k = 0; k < N; k++) begin
      int j = e - k - 2;
      bit expV = (j >= 15 && j <= LAST_CUR && ((j - 15) % 4) == 3);
      checks++;
      if (sadValid[k] !== expV) fail("R7/R8", "valid", k, sadValid[k], expV);
      if (expV && sadValid[k]) begin
        int p = (j - 15) / 64;
        int dx = 7 - k;
        int dy = p - 8;
        int s = ((j - 15) / 16) % 4;
        int x = (j - 15) % 16;
        int es = expSad(j, dx, dy);
        int aDx = $signed(mvDx[k*MW +: MW]);
        int aDy = $signed(mvDy[k*MW +: MW]);
        emitted[k]++;
        checks++;
        if (int'(sadVal[k*SW +: SW]) != es) fail("R3/R4/R6", "sad", k, int'(sadVal[k*SW +: SW]), es);
        checks++;
        if (aDx != dx || aDy != dy) fail("R5", "mv", k, aDx*100 + aDy, dx*100 + dy);
        checks++;
        if (int'(blkIdx[k*BW +: BW]) != 4*s + x/4) fail("R6", "blk", k, int'(blkIdx[k*BW +: BW]), 4*s + x/4);
      end
    end
  endtask

  task automatic runSearch(bit pokeBusy);
    fillPixels();
    for (int k = 0; k < N; k++) emitted[k] = 0;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    for (int e = 0; e <= DONE_EDGE + 4; e++) begin
      @(negedge clk);
      checkCycle(e);
      start   = pokeBusy && (e == 500);   // R2: ignored while busy
      curCol  = curFor(e);
      refColA = refFor(e, 0);
      refColB = refFor(e, 1);
      @(posedge clk);
    end
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < N; k++) begin
      checks++;
      if (emitted[k] != 256) fail("R10", "count", k, emitted[k], 256);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;   // R1 reset state
    if (busy !== 1'b0 || done !== 1'b0 || sadValid !== '0)
      fail("R1", "reset", -1, {busy, done, |sadValid}, 0);
    runSearch(1'b0);
    runSearch(1'b1);
    checks++;   // R1 quiet when idle
    if (busy !== 1'b0 || sadValid !== '0) fail("R1", "idle", -1, {busy, |sadValid}, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule